// File: doc/BRIEF.md
# 64-bit Alarm Timer

This block is a general-purpose timer for a 32-bit register bus. A 64-bit counter moves up or down by one on each tick of a programmable prescaler. The prescaler divides one of two clock-enable inputs: a fast enable or a crystal enable. Software works the timer through word registers.

The live count is never read directly. A write to a snapshot register captures the count, and two read-only words then return that captured value, so the two halves always match. A 64-bit alarm value is compared with the counter after every tick. An armed match sets an interrupt, disarms the alarm and can reload the counter from a 64-bit load value. The same load value can be copied into the counter at any time through a trigger register.

The interrupt path has an enable word, a raw word, a masked-status word and a write-one-to-clear word. The timer uses bit 0 in each of them.

Top module: `timer64_alarm`

## Requirements
- R1: After reset the configuration word reads 0, a snapshot reads count 0, the interrupt enable and raw words read 0, and `irq` is low.
- R2: A write of any data to word offset 0x0C copies the live count into the read words at 0x04 (bits 31:0) and 0x08 (bits 63:32). Those words keep that value until the next snapshot write, even while the counter runs.
- R3: When configuration bit 31 (enable) is 0, the counter holds its value. Clearing bit 31 stops the count without changing it.
- R4: When configuration bit 30 is 1, each tick adds one to the count. When it is 0, each tick subtracts one. The count wraps modulo 2^64 in both directions.
- R5: Configuration bits 28:13 hold a divider D. While enabled, one tick occurs for every D selected source enables. D=0 divides by 65536, and D=1 and D=2 both divide by 2. Every write to the configuration word restarts the prescaler phase, and no tick occurs in the cycle of that write.
- R6: Configuration bit 9 selects the source: 0 uses `fast_en` and 1 uses `xtal_en`. The source that is not selected has no effect on the count.
- R7: The load value is written at 0x18 (bits 31:0) and 0x1C (bits 63:32). A write to 0x20 copies it into the counter, and this load takes priority over a tick in the same cycle.
- R8: The alarm value is written at 0x10 (bits 31:0) and 0x14 (bits 63:32). When configuration bit 10 (arm) is 1 and a tick makes the count exactly equal to the alarm value, raw bit 0 is set and bit 10 clears itself, so a later match does not fire again.
- R9: When configuration bit 29 (auto-reload) is 1 and the alarm fires, the counter takes the load value instead of the matching count.
- R10: The interrupt enable word is at 0x24, raw at 0x28, masked status at 0x2C and clear at 0x30, with the timer on bit 0. Status equals raw AND enable, `irq` is the OR of the status bits, and writing 1 to a clear bit resets that raw bit.
- R11: With bit 10 at 0, the counter runs through the alarm value without setting the raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_en | input | 1 | Fast source clock enable |
| xtal_en | input | 1 | Crystal source clock enable |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the alarm firing a second time after auto-reload has put the counter back just below the alarm value. The counter has to cross the alarm twice in one run. The bench sets this up by loading a start value three ticks below the alarm and a reload value one below it. The count then shows whether the alarm disarmed itself. The 65536 divide for a zero divider is reached by one long directed run. A seeded random loop varies the start values, directions, dividers and run lengths, and includes the wrap-around cases.

// File: rtl/timer64_pkg.sv
package timer64_pkg;

  localparam int CNT_W  = 64;
  localparam int DIV_W  = 16;
  localparam int WORD_W = 32;

  // word indices (byte offset / 4)
  localparam logic [3:0] W_CFG   = 4'd0;
  localparam logic [3:0] W_SNLO  = 4'd1;
  localparam logic [3:0] W_SNHI  = 4'd2;
  localparam logic [3:0] W_SNAP  = 4'd3;
  localparam logic [3:0] W_ALLO  = 4'd4;
  localparam logic [3:0] W_ALHI  = 4'd5;
  localparam logic [3:0] W_LDLO  = 4'd6;
  localparam logic [3:0] W_LDHI  = 4'd7;
  localparam logic [3:0] W_LDGO  = 4'd8;
  localparam logic [3:0] W_IEN   = 4'd9;
  localparam logic [3:0] W_IRAW  = 4'd10;
  localparam logic [3:0] W_IST   = 4'd11;
  localparam logic [3:0] W_ICLR  = 4'd12;

  // configuration bit positions
  localparam int B_RUN    = 31;
  localparam int B_UP     = 30;
  localparam int B_RELOAD = 29;
  localparam int B_DIV_HI = 28;
  localparam int B_DIV_LO = 13;
  localparam int B_ARM    = 10;
  localparam int B_SRC    = 9;

  // one count step, wrapping modulo 2^CNT_W
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic up);
    return up ? c + 1'b1 : c - 1'b1;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int EFF_W = DIV_W + 1;

  // divider value actually used: 0 -> 2^DIV_W, 1 and 2 -> 2
  function automatic logic [EFF_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    if (d == '0)
      return EFF_W'(1) << DIV_W;
    else if (d <= DIV_W'(2))
      return EFF_W'(2);
    else
      return {1'b0, d};
  endfunction

  logic [DIV_W-1:0] phase;
  logic             last;
  logic             step;

  assign last = ({1'b0, phase} == (eff_div(div) - 1'b1));
  assign step = run & src_en & ~restart;
  assign tick = step & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (restart)
      phase <= '0;
    else if (step)
      phase <= last ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import timer64_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             up,
  input  logic             arm,
  input  logic             reload_en,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic [CNT_W-1:0] nxt;

  assign nxt  = step_count(count, up);
  assign fire = tick & ~load_now & arm & (nxt == alarm_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (load_now)
      count <= load_val;
    else if (tick)
      count <= (fire && reload_en) ? load_val : nxt;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N_IRQ = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] set,
  input  logic             clr_wr,
  input  logic [N_IRQ-1:0] clr_mask,
  input  logic [N_IRQ-1:0] ena,
  output logic [N_IRQ-1:0] raw,
  output logic [N_IRQ-1:0] status,
  output logic             irq
);
  logic [N_IRQ-1:0] clr;

  assign clr    = clr_wr ? clr_mask : '0;
  assign status = raw & ena;
  assign irq    = |status;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      raw <= '0;
    else
      raw <= (raw & ~clr) | set;
  end
endmodule

// File: rtl/timer64_alarm.sv
module timer64_alarm
  import timer64_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_IRQ  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_en,
  input  logic              xtal_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  // configuration fields
  logic             cfg_en, cfg_up, cfg_reload, cfg_arm, cfg_src;
  logic [DIV_W-1:0] cfg_div;

  logic [CNT_W-1:0] alarm_q, load_q, snap_q, count;
  logic [N_IRQ-1:0] int_ena, irq_raw, irq_status, irq_set;

  logic [IDX_W-1:0] widx;
  logic             wr_hit;
  logic             cfg_wr, snap_wr, load_now, clr_wr;
  logic             src_en, tick, fire;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign wr_hit   = bus_sel & bus_wr;
  assign cfg_wr   = wr_hit & (widx == IDX_W'(W_CFG));
  assign snap_wr  = wr_hit & (widx == IDX_W'(W_SNAP));
  assign load_now = wr_hit & (widx == IDX_W'(W_LDGO));
  assign clr_wr   = wr_hit & (widx == IDX_W'(W_ICLR));
  assign src_en   = cfg_src ? xtal_en : fast_en;

  // configuration word; the arm bit self-clears on a fire
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      cfg_up     <= 1'b0;
      cfg_reload <= 1'b0;
      cfg_arm    <= 1'b0;
      cfg_src    <= 1'b0;
      cfg_div    <= '0;
    end else if (cfg_wr) begin
      cfg_en     <= bus_wdata[B_RUN];
      cfg_up     <= bus_wdata[B_UP];
      cfg_reload <= bus_wdata[B_RELOAD];
      cfg_arm    <= bus_wdata[B_ARM];
      cfg_src    <= bus_wdata[B_SRC];
      cfg_div    <= bus_wdata[B_DIV_HI:B_DIV_LO];
    end else if (fire) begin
      cfg_arm    <= 1'b0;
    end
  end

  // data words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      load_q  <= '0;
      snap_q  <= '0;
      int_ena <= '0;
    end else begin
      if (snap_wr) snap_q <= count;
      if (wr_hit) begin
        case (widx)
          IDX_W'(W_ALLO): alarm_q[31:0]  <= bus_wdata;
          IDX_W'(W_ALHI): alarm_q[63:32] <= bus_wdata;
          IDX_W'(W_LDLO): load_q[31:0]   <= bus_wdata;
          IDX_W'(W_LDHI): load_q[63:32]  <= bus_wdata;
          IDX_W'(W_IEN):  int_ena        <= bus_wdata[N_IRQ-1:0];
          default: ;
        endcase
      end
    end
  end

  tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg_en),
    .src_en  (src_en),
    .restart (cfg_wr),
    .div     (cfg_div),
    .tick    (tick)
  );

  tmr_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .up        (cfg_up),
    .arm       (cfg_arm),
    .reload_en (cfg_reload),
    .load_now  (load_now),
    .load_val  (load_q),
    .alarm_val (alarm_q),
    .count     (count),
    .fire      (fire)
  );

  // the timer's own source is bit 0; any further bits stay unused
  generate
    if (N_IRQ > 1) begin : g_multi
      assign irq_set = {{(N_IRQ-1){1'b0}}, fire};
    end else begin : g_single
      assign irq_set = fire;
    end
  endgenerate

  tmr_irq #(.N_IRQ(N_IRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (irq_set),
    .clr_wr   (clr_wr),
    .clr_mask (bus_wdata[N_IRQ-1:0]),
    .ena      (int_ena),
    .raw      (irq_raw),
    .status   (irq_status),
    .irq      (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (widx)
      IDX_W'(W_CFG):  bus_rdata = {cfg_en, cfg_up, cfg_reload, cfg_div, 2'b00,
                                   cfg_arm, cfg_src, 9'd0};
      IDX_W'(W_SNLO): bus_rdata = snap_q[31:0];
      IDX_W'(W_SNHI): bus_rdata = snap_q[63:32];
      IDX_W'(W_ALLO): bus_rdata = alarm_q[31:0];
      IDX_W'(W_ALHI): bus_rdata = alarm_q[63:32];
      IDX_W'(W_LDLO): bus_rdata = load_q[31:0];
      IDX_W'(W_LDHI): bus_rdata = load_q[63:32];
      IDX_W'(W_IEN):  bus_rdata[N_IRQ-1:0] = int_ena;
      IDX_W'(W_IRAW): bus_rdata[N_IRQ-1:0] = irq_raw;
      IDX_W'(W_IST):  bus_rdata[N_IRQ-1:0] = irq_status;
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import timer64_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             fire,
  input logic             load_now,
  input logic             cfg_en,
  input logic             cfg_up,
  input logic             cfg_arm,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load_q,
  input logic             int_ena0,
  input logic             raw0,
  input logic             irq
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !load_now) |=> $stable(count));

  p_tick_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> cfg_en);

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fire && !load_now && cfg_up) |=> (count == $past(count) + 64'd1));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (count == $past(load_q)));

  p_fire_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!cfg_arm && raw0));

  p_fire_needs_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> cfg_arm);

  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ena0 |-> !irq);
endmodule

bind timer64_alarm tmr_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .fire     (fire),
  .load_now (load_now),
  .cfg_en   (cfg_en),
  .cfg_up   (cfg_up),
  .cfg_arm  (cfg_arm),
  .count    (count),
  .load_q   (load_q),
  .int_ena0 (int_ena[0]),
  .raw0     (irq_raw[0]),
  .irq      (irq)
);

// File: tb/timer64_alarm_tb.sv
module timer64_alarm_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [5:0] A_CFG = 6'h00, A_SNLO = 6'h04, A_SNHI = 6'h08, A_SNAP = 6'h0C,
                         A_ALLO = 6'h10, A_ALHI = 6'h14, A_LDLO = 6'h18, A_LDHI = 6'h1C,
                         A_LDGO = 6'h20, A_IEN = 6'h24, A_IRAW = 6'h28, A_IST = 6'h2C,
                         A_ICLR = 6'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_en = 1'b1, xtal_en = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer64_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .xtal_en(xtal_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] mkcfg(input logic en, input logic up, input logic rl,
                                        input logic [15:0] dv, input logic arm,
                                        input logic src);
    logic [31:0] c;
    c = '0;
    c[31] = en; c[30] = up; c[29] = rl; c[28:13] = dv; c[10] = arm; c[9] = src;
    return c;
  endfunction

  function automatic int model_div(input logic [15:0] d);
    if (d == 0) return 65536;
    if (d <= 2) return 2;
    return int'(d);
  endfunction

  function automatic logic [63:0] model_move(input logic [63:0] s, input logic up,
                                             input int n);
    return up ? s + 64'(n) : s - 64'(n);
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    wr(A_SNAP, 32'hABC);
    rd(A_SNLO, lo);
    rd(A_SNHI, hi);
    v = {hi, lo};
  endtask

  task automatic load64(input logic [63:0] v);
    wr(A_LDLO, v[31:0]);
    wr(A_LDHI, v[63:32]);
    wr(A_LDGO, 32'd0);
  endtask

  task automatic set_alarm(input logic [63:0] v);
    wr(A_ALLO, 32'hFFFF_FFFF);
    wr(A_ALHI, v[63:32]);
    wr(A_ALLO, v[31:0]);
  endtask

  // runs for m+2 enabled edges, reads the config word mid-run, then stops
  task automatic run_for(input logic [31:0] cfg, input int m, output logic [31:0] cfg_rb);
    wr(A_CFG, cfg);
    repeat (m) @(negedge clk);
    rd(A_CFG, cfg_rb);
    wr(A_CFG, cfg & ~32'h8000_0400);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, cb;
    logic [63:0] v, v1, al;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CFG, r);  check(r == 0, "R1 cfg", 64'(r), 0);
    rd(A_IRAW, r); check(r == 0, "R1 raw", 64'(r), 0);
    rd(A_IEN, r);  check(r == 0, "R1 ena", 64'(r), 0);
    check(irq == 1'b0, "R1 irq", 64'(irq), 0);
    rd64(v);       check(v == 0, "R1 count", v, 0);

    // R7 load, R3 hold while disabled (running with en=0)
    load64(64'h1234_5678_9ABC_DEF0);
    run_for(mkcfg(1'b0, 1'b1, 1'b0, 16'd3, 1'b0, 1'b0), 10, cb);
    rd64(v); check(v == 64'h1234_5678_9ABC_DEF0, "R7 R3 load/hold", v, 64'h1234_5678_9ABC_DEF0);

    // R4 up wrap, divider 1 treated as 2 (R5)
    load64(64'hFFFF_FFFF_FFFF_FFFE);
    run_for(mkcfg(1'b1, 1'b1, 1'b0, 16'd1, 1'b0, 1'b0), 6, cb);
    rd64(v); check(v == 64'd2, "R4 up wrap", v, 64'd2);

    // R4 down wrap
    load64(64'd1);
    run_for(mkcfg(1'b1, 1'b0, 1'b0, 16'd2, 1'b0, 1'b0), 4, cb);
    rd64(v); check(v == 64'hFFFF_FFFF_FFFF_FFFE, "R4 down wrap", v, 64'hFFFF_FFFF_FFFF_FFFE);

    // R5 divider 5: 23 edges -> 4 ticks
    load64(64'd100);
    run_for(mkcfg(1'b1, 1'b1, 1'b0, 16'd5, 1'b0, 1'b0), 21, cb);
    rd64(v); check(v == 64'd104, "R5 div5", v, 64'd104);

    // R6 source select: crystal selected but idle, fast toggling
    load64(64'd0);
    fast_en = 1'b1; xtal_en = 1'b0;
    run_for(mkcfg(1'b1, 1'b1, 1'b0, 16'd2, 1'b0, 1'b1), 20, cb);
    rd64(v); check(v == 0, "R6 unselected ignored", v, 0);
    fast_en = 1'b0; xtal_en = 1'b1;
    run_for(mkcfg(1'b1, 1'b1, 1'b0, 16'd2, 1'b0, 1'b1), 20, cb);
    rd64(v); check(v == 64'd11, "R6 xtal counts", v, 64'd11);
    fast_en = 1'b1; xtal_en = 1'b0;

    // R2 snapshot holds while running
    load64(64'd500);
    wr(A_CFG, mkcfg(1'b1, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0));
    repeat (6) @(negedge clk);
    rd64(v);
    repeat (10) @(negedge clk);
    rd(A_SNLO, r); check(r == v[31:0], "R2 snapshot hold", 64'(r), 64'(v[31:0]));
    wr(A_CFG, 32'd0);
    rd64(v1); check(v1 > v, "R2 new snapshot", v1, v);

    // R8/R10 alarm fires, no reload
    al = 64'h0000_0001_0000_0010;
    wr(A_IEN, 32'd1);
    load64(al - 64'd3);
    set_alarm(al);
    run_for(mkcfg(1'b1, 1'b1, 1'b0, 16'd2, 1'b1, 1'b0), 8, cb);
    check(cb[10] == 1'b0, "R8 arm self-clear", 64'(cb[10]), 0);
    rd64(v); check(v == al + 64'd2, "R8 count past alarm", v, al + 64'd2);
    rd(A_IRAW, r); check(r == 32'd1, "R8 raw set", 64'(r), 1);
    rd(A_IST, r);  check(r == 32'd1, "R10 status", 64'(r), 1);
    check(irq == 1'b1, "R10 irq", 64'(irq), 1);
    wr(A_ICLR, 32'd1);
    rd(A_IRAW, r); check(r == 32'd0, "R10 clear", 64'(r), 0);
    check(irq == 1'b0, "R10 irq cleared", 64'(irq), 0);

    // R9 auto-reload to just below alarm; R8 no second fire
    load64(al - 64'd3);
    wr(A_LDLO, 32'h0000_000F); // reload value al-1
    run_for(mkcfg(1'b1, 1'b1, 1'b1, 16'd2, 1'b1, 1'b0), 8, cb);
    rd64(v); check(v == al + 64'd1, "R9 R8 reload once", v, al + 64'd1);
    wr(A_IEN, 32'd0);
    rd(A_IRAW, r); check(r == 32'd1, "R9 raw", 64'(r), 1);
    rd(A_IST, r);  check(r == 32'd0, "R10 masked", 64'(r), 0);
    check(irq == 1'b0, "R10 irq masked", 64'(irq), 0);
    wr(A_ICLR, 32'd1);

    // R11 disarmed passes the alarm value
    load64(al - 64'd3);
    run_for(mkcfg(1'b1, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0), 8, cb);
    rd64(v); check(v == al + 64'd2, "R11 counts on", v, al + 64'd2);
    rd(A_IRAW, r); check(r == 32'd0, "R11 no raw", 64'(r), 0);

    // R5 random dividers and directions, R4
    for (int i = 0; i < 20; i++) begin
      logic [63:0] s;
      logic        up;
      logic [15:0] dv;
      int          m;
      s  = {$urandom(), $urandom()};
      if (i % 5 == 0) s = (i % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFFD : 64'd2;
      up = 1'($urandom());
      dv = 16'($urandom_range(1, 9));
      m  = $urandom_range(0, 40);
      load64(s);
      run_for(mkcfg(1'b1, up, 1'b0, dv, 1'b0, 1'b0), m, cb);
      rd64(v);
      v1 = model_move(s, up, (m + 2) / model_div(dv));
      check(v == v1, "R5 R4 random run", v, v1);
    end

    // R5 divider 0 -> 65536: 65536 enabled edges give one tick
    load64(64'd7);
    run_for(mkcfg(1'b1, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0), 65534, cb);
    rd64(v); check(v == 64'd8, "R5 div zero", v, 64'd8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule